// File: doc/BRIEF.md
# Indirect Rule-Table Access Controller

This block sits between a host register bus and the storage of a packet classifier. The classifier has a rule table in which every entry holds eight 32-bit key words and eight 32-bit mask words. It also has a per-entry action word and a per-entry meter word. The host never addresses the storage directly. It stages data in window registers and then launches an operation through a single control register. That register carries an entry index, an operation code, a storage select and a start bit. Hardware clears the start bit when the operation completes.

There are three operations. A read copies an entry into the windows. A write copies the windows into an entry. A search scans the rule table upward from the programmed index. The scan stops on every entry whose two slice-valid bits are not both zero. It then reports that entry's index and loads its key and mask into the windows. It stays parked until the host reads key word 7, which must be the host's last read. A separate clear bit wipes every rule entry, one entry per cycle, and then drops by itself.

A rule is removed by reading it, clearing the slice-valid bits in the key word 0 window, and writing it back. Entry 0 is reserved: it can never be written and the scan never reports it.

Top module: `rule_access_ctrl`

## Requirements
- R1: Register indices: 0 = control, 1..8 = key words 0..7, 9..16 = mask words 0..7, 17 = action word, 18 = meter word; any other index reads zero. Control register bits: [0] start, [2:1] operation (1 read, 2 write, 3 search, 0 none), [4:3] storage select (0 rule table, 1 action, 2 meter), [5] clear, [6] hit, [8+ADDR_W-1:8] entry index. After reset every register reads zero.
- R2: A read completes on the second clock edge after the control write. At that edge the start bit drops and the windows of the selected storage take the entry's contents.
- R3: A write completes on the second clock edge after the control write. It copies the windows of the selected storage into the entry, except that a rule-table write to entry 0 leaves that entry unchanged.
- R4: A control write while the start bit or the clear bit is set is ignored entirely.
- R5: A search starts at the programmed index. It spends two cycles per entry, and the index field shows the entry being examined. Entry 0 and entries whose key word 0 bits [1:0] are both zero are skipped.
- R6: On a hit, the hit bit rises, the index field holds the entry, and the key and mask windows are loaded. The scan holds until a host read of key word 7; reads of other registers do not release it, and such a read outside a hit has no effect.
- R7: When the last entry has been examined, or has been released after a hit, the start bit drops and the hit bit is zero.
- R8: Setting the clear bit zeroes the key and mask of every entry, one entry per cycle, after which the clear bit drops; action and meter words are kept.
- R9: When a read or a hit loads the windows on the same edge as a host write to a window register, the loaded storage value wins.
- R10: An entry removed by clearing its slice-valid bits and writing it back is no longer reported by a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect on key word 7 only) |
| host_addr | input | 5 | Register index |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data of the indexed register, combinational |

## Verification
Two things can land on the same clock edge. One is the completion of a read or a search hit, which loads the windows. The other is a host write into one of those same window registers. The bench provokes this by writing key word 1 exactly two edges after launching a read. It then reads the word back, and the reference model, which applies the host write first and the storage load second, predicts that the storage value is returned. Every cycle, the bench also compares the register the host is addressing against its model, including the index field as it walks during a scan, so the cycle on which a hit, a release or a completion occurs is pinned exactly.

// File: rtl/rule_access_pkg.sv
package rule_access_pkg;
   typedef enum logic [1:0] {OP_NONE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2, OP_SEARCH = 2'd3} op_e;
   typedef enum logic [1:0] {SEL_RULE = 2'd0, SEL_ACT = 2'd1, SEL_METER = 2'd2, SEL_NONE = 2'd3} sel_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT1 = 2'd1, ST_WAIT2 = 2'd2, ST_PARK = 2'd3} phase_e;

   localparam int KEY_WORDS = 8;
   localparam int REG_AW    = 5;
   localparam int IDX_CTRL  = 0;
   localparam int IDX_KEY0  = 1;
   localparam int IDX_MASK0 = IDX_KEY0 + KEY_WORDS;
   localparam int IDX_ACT   = IDX_MASK0 + KEY_WORDS;
   localparam int IDX_METER = IDX_ACT + 1;

   localparam int BIT_START = 0;
   localparam int BIT_OP    = 1;
   localparam int BIT_SEL   = 3;
   localparam int BIT_CLEAR = 5;
   localparam int BIT_HIT   = 6;
   localparam int BIT_INDEX = 8;
endpackage

// File: rtl/rule_store.sv
module rule_store
   import rule_access_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DW     = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              idx,
   input  logic                           we,
   input  sel_e                           we_sel,
   input  logic [KEY_WORDS-1:0][DW-1:0]   in_key,
   input  logic [KEY_WORDS-1:0][DW-1:0]   in_mask,
   input  logic [DW-1:0]                  in_act,
   input  logic [DW-1:0]                  in_met,
   input  logic                           wipe,
   input  logic [ADDR_W-1:0]              wipe_idx,
   output logic [KEY_WORDS-1:0][DW-1:0]   out_key,
   output logic [KEY_WORDS-1:0][DW-1:0]   out_mask,
   output logic [DW-1:0]                  out_act,
   output logic [DW-1:0]                  out_met
);
   localparam int ENTRIES = 1 << ADDR_W;

   logic [KEY_WORDS-1:0][DW-1:0] key_mem  [ENTRIES];
   logic [KEY_WORDS-1:0][DW-1:0] mask_mem [ENTRIES];
   logic [DW-1:0]                act_mem  [ENTRIES];
   logic [DW-1:0]                met_mem  [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            key_mem[i]  <= '0;
            mask_mem[i] <= '0;
            act_mem[i]  <= '0;
            met_mem[i]  <= '0;
         end
      end else if (wipe) begin
         key_mem[wipe_idx]  <= '0;
         mask_mem[wipe_idx] <= '0;
      end else if (we) begin
         case (we_sel)
            SEL_RULE: if (idx != '0) begin
               key_mem[idx]  <= in_key;
               mask_mem[idx] <= in_mask;
            end
            SEL_ACT:   act_mem[idx] <= in_act;
            SEL_METER: met_mem[idx] <= in_met;
            default: ;
         endcase
      end
   end

   assign out_key  = key_mem[idx];
   assign out_mask = mask_mem[idx];
   assign out_act  = act_mem[idx];
   assign out_met  = met_mem[idx];

   p_reserved_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wipe && we_sel == SEL_RULE && idx == '0) |=> $stable(key_mem[0]))
      else $error("entry 0 changed by a rule write");
endmodule

// File: rtl/rule_access_seq.sv
module rule_access_seq
   import rule_access_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              in_start,
   input  logic              in_clear,
   input  op_e               in_op,
   input  sel_e              in_sel,
   input  logic [ADDR_W-1:0] in_index,
   input  logic              rel_rd,
   input  logic              slice_ok,
   output logic              start,
   output logic              clearing,
   output logic              hit,
   output op_e               op,
   output sel_e              sel,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] wipe_idx,
   output logic              mem_we,
   output logic              load_rule,
   output logic              load_act,
   output logic              load_met
);
   localparam logic [ADDR_W-1:0] LAST = '1;

   phase_e phase;
   logic   done, found;

   assign done      = (phase == ST_WAIT2);
   assign found     = done && op == OP_SEARCH && slice_ok && ptr != '0;
   assign mem_we    = done && op == OP_WRITE;
   assign load_rule = found || (done && op == OP_READ && sel == SEL_RULE);
   assign load_act  = done && op == OP_READ && sel == SEL_ACT;
   assign load_met  = done && op == OP_READ && sel == SEL_METER;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= ST_IDLE;
         start    <= 1'b0;
         clearing <= 1'b0;
         hit      <= 1'b0;
         op       <= OP_NONE;
         sel      <= SEL_RULE;
         ptr      <= '0;
         wipe_idx <= '0;
      end else begin
         if (clearing) begin
            if (wipe_idx == LAST) clearing <= 1'b0;
            else                  wipe_idx <= wipe_idx + 1'b1;
         end
         case (phase)
            ST_IDLE: if (ctrl_we && !clearing) begin
               if (in_clear) begin
                  clearing <= 1'b1;
                  wipe_idx <= '0;
               end else begin
                  op  <= in_op;
                  sel <= in_sel;
                  ptr <= in_index;
                  if (in_start) begin
                     start <= 1'b1;
                     phase <= ST_WAIT1;
                  end
               end
            end
            ST_WAIT1: phase <= ST_WAIT2;
            ST_WAIT2: begin
               if (op != OP_SEARCH) begin
                  start <= 1'b0;
                  phase <= ST_IDLE;
               end else if (found) begin
                  hit   <= 1'b1;
                  phase <= ST_PARK;
               end else if (ptr == LAST) begin
                  start <= 1'b0;
                  phase <= ST_IDLE;
               end else begin
                  ptr   <= ptr + 1'b1;
                  phase <= ST_WAIT1;
               end
            end
            ST_PARK: if (rel_rd) begin
               hit <= 1'b0;
               if (ptr == LAST) begin
                  start <= 1'b0;
                  phase <= ST_IDLE;
               end else begin
                  ptr   <= ptr + 1'b1;
                  phase <= ST_WAIT1;
               end
            end
            default: phase <= ST_IDLE;
         endcase
      end
   end

   p_two_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start) && op != OP_SEARCH) |=> start ##1 !start)
      else $error("access latency is not two cycles");
   p_busy_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((start || clearing) && ctrl_we) |=> ($stable(op) && $stable(sel)))
      else $error("control write accepted while busy");
   p_hit_in_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (start && op == OP_SEARCH))
      else $error("hit outside a search");
   p_park_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !rel_rd) |=> (hit && $stable(ptr)))
      else $error("scan moved without release");
   p_scan_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && rel_rd && ptr == LAST) |=> (!start && !hit))
      else $error("scan did not end after last entry");
   p_clear_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clearing && wipe_idx == LAST) |=> !clearing)
      else $error("clear bit did not drop");
endmodule

// File: rtl/rule_access_ctrl.sv
module rule_access_ctrl
   import rule_access_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [4:0]        host_addr,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("ADDR_W must lie in 1..8");
      end
      if (DW < 16) begin : g_bad_dw
         $error("DW must be at least 16");
      end
   endgenerate

   logic [KEY_WORDS-1:0][DW-1:0] win_key, win_mask, st_key, st_mask;
   logic [DW-1:0]                win_act, win_met, st_act, st_met;
   logic [DW-1:0]                ctrl_val;
   logic                         ctrl_we, rel_rd, slice_ok;
   logic                         start, clearing, hit, mem_we;
   logic                         load_rule, load_act, load_met;
   op_e                          op;
   sel_e                         sel;
   logic [ADDR_W-1:0]            ptr, wipe_idx;

   assign ctrl_we  = host_wr && host_addr == REG_AW'(IDX_CTRL);
   assign rel_rd   = host_rd && host_addr == REG_AW'(IDX_KEY0 + KEY_WORDS - 1);
   assign slice_ok = st_key[0][1:0] != 2'b00;

   rule_access_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
      .in_start(host_wdata[BIT_START]), .in_clear(host_wdata[BIT_CLEAR]),
      .in_op(op_e'(host_wdata[BIT_OP +: 2])), .in_sel(sel_e'(host_wdata[BIT_SEL +: 2])),
      .in_index(host_wdata[BIT_INDEX +: ADDR_W]), .rel_rd(rel_rd), .slice_ok(slice_ok),
      .start(start), .clearing(clearing), .hit(hit), .op(op), .sel(sel), .ptr(ptr),
      .wipe_idx(wipe_idx), .mem_we(mem_we), .load_rule(load_rule),
      .load_act(load_act), .load_met(load_met)
   );

   rule_store #(.ADDR_W(ADDR_W), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .idx(ptr), .we(mem_we), .we_sel(sel),
      .in_key(win_key), .in_mask(win_mask), .in_act(win_act), .in_met(win_met),
      .wipe(clearing), .wipe_idx(wipe_idx),
      .out_key(st_key), .out_mask(st_mask), .out_act(st_act), .out_met(st_met)
   );

   for (genvar k = 0; k < KEY_WORDS; k++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_key[k]  <= '0;
            win_mask[k] <= '0;
         end else if (load_rule) begin
            win_key[k]  <= st_key[k];
            win_mask[k] <= st_mask[k];
         end else if (host_wr) begin
            if (host_addr == REG_AW'(IDX_KEY0 + k))  win_key[k]  <= host_wdata;
            if (host_addr == REG_AW'(IDX_MASK0 + k)) win_mask[k] <= host_wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_act <= '0;
         win_met <= '0;
      end else begin
         if (load_act)                                      win_act <= st_act;
         else if (host_wr && host_addr == REG_AW'(IDX_ACT)) win_act <= host_wdata;
         if (load_met)                                        win_met <= st_met;
         else if (host_wr && host_addr == REG_AW'(IDX_METER)) win_met <= host_wdata;
      end
   end

   always_comb begin
      ctrl_val                    = '0;
      ctrl_val[BIT_START]         = start;
      ctrl_val[BIT_OP +: 2]       = op;
      ctrl_val[BIT_SEL +: 2]      = sel;
      ctrl_val[BIT_CLEAR]         = clearing;
      ctrl_val[BIT_HIT]           = hit;
      ctrl_val[BIT_INDEX +: ADDR_W] = ptr;
      host_rdata = '0;
      if (host_addr == REG_AW'(IDX_CTRL))       host_rdata = ctrl_val;
      else if (host_addr == REG_AW'(IDX_ACT))   host_rdata = win_act;
      else if (host_addr == REG_AW'(IDX_METER)) host_rdata = win_met;
      else if (host_addr >= REG_AW'(IDX_KEY0) && host_addr < REG_AW'(IDX_MASK0))
         host_rdata = win_key[3'(host_addr - REG_AW'(IDX_KEY0))];
      else if (host_addr >= REG_AW'(IDX_MASK0) && host_addr < REG_AW'(IDX_ACT))
         host_rdata = win_mask[3'(host_addr - REG_AW'(IDX_MASK0))];
   end

   p_hit_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit) |-> (win_key[0][1:0] != 2'b00 && ptr != '0))
      else $error("hit on an invalid or reserved entry");
   p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_rule && host_wr && host_addr == REG_AW'(IDX_KEY0 + 1)) |=> win_key[1] == $past(st_key[1]))
      else $error("host write beat storage load");
endmodule

// File: tb/rule_access_ctrl_test.sv
`timescale 1ns/1ps
module rule_access_ctrl_test;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   rule_access_ctrl #(.ADDR_W(4), .DW(32)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   // behavioural reference model
   bit          m_go, m_clr, m_hit;
   int          m_op, m_sel, m_addr, m_cnt, m_cp;
   logic [31:0] mk [N][8];
   logic [31:0] mm [N][8];
   logic [31:0] ma [N];
   logic [31:0] mt [N];
   logic [31:0] wk [8];
   logic [31:0] wm [8];
   logic [31:0] wa, wt;

   task automatic model_reset();
      m_go = 0; m_clr = 0; m_hit = 0; m_op = 0; m_sel = 0; m_addr = 0; m_cnt = 0; m_cp = 0;
      wa = 0; wt = 0;
      for (int i = 0; i < N; i++) begin
         ma[i] = 0; mt[i] = 0;
         for (int w = 0; w < 8; w++) begin mk[i][w] = 0; mm[i][w] = 0; end
      end
      for (int w = 0; w < 8; w++) begin wk[w] = 0; wm[w] = 0; end
   endtask

   function automatic logic [31:0] model_rd(input int a);
      logic [31:0] v = 0;
      if (a == 0) v = (m_addr << 8) | (m_hit << 6) | (m_clr << 5) | (m_sel << 3) | (m_op << 1) | m_go;
      else if (a >= 1 && a <= 8)  v = wk[a-1];
      else if (a >= 9 && a <= 16) v = wm[a-9];
      else if (a == 17) v = wa;
      else if (a == 18) v = wt;
      return v;
   endfunction

   task automatic model_step();
      bit busy = m_go || m_clr;
      bit rel = host_rd && host_addr == 5'd8;
      int a = host_addr;
      logic [31:0] d = host_wdata;
      bit ld_rule = 0, ld_act = 0, ld_met = 0;
      int li = 0;
      if (m_clr) begin
         for (int w = 0; w < 8; w++) begin mk[m_cp][w] = 0; mm[m_cp][w] = 0; end
         if (m_cp == N-1) m_clr = 0; else m_cp++;
      end
      if (m_go) begin
         if (m_hit) begin
            if (rel) begin
               m_hit = 0;
               if (m_addr == N-1) m_go = 0; else begin m_addr++; m_cnt = 2; end
            end
         end else begin
            m_cnt--;
            if (m_cnt == 0) begin
               if (m_op == 3) begin
                  if (m_addr != 0 && mk[m_addr][0][1:0] != 0) begin
                     ld_rule = 1; li = m_addr; m_hit = 1;
                  end else if (m_addr == N-1) m_go = 0;
                  else begin m_addr++; m_cnt = 2; end
               end else begin
                  if (m_op == 1) begin
                     li = m_addr;
                     if (m_sel == 0) ld_rule = 1;
                     if (m_sel == 1) ld_act = 1;
                     if (m_sel == 2) ld_met = 1;
                  end else if (m_op == 2) begin
                     if (m_sel == 0 && m_addr != 0)
                        for (int w = 0; w < 8; w++) begin mk[m_addr][w] = wk[w]; mm[m_addr][w] = wm[w]; end
                     if (m_sel == 1) ma[m_addr] = wa;
                     if (m_sel == 2) mt[m_addr] = wt;
                  end
                  m_go = 0;
               end
            end
         end
      end
      if (host_wr) begin
         if (a >= 1 && a <= 8) wk[a-1] = d;
         else if (a >= 9 && a <= 16) wm[a-9] = d;
         else if (a == 17) wa = d;
         else if (a == 18) wt = d;
      end
      if (ld_rule) for (int w = 0; w < 8; w++) begin wk[w] = mk[li][w]; wm[w] = mm[li][w]; end
      if (ld_act) wa = ma[li];
      if (ld_met) wt = mt[li];
      if (host_wr && a == 0 && !busy) begin
         if (d[5]) begin m_clr = 1; m_cp = 0; end
         else begin
            m_op = d[2:1]; m_sel = d[4:3]; m_addr = d[11:8];
            if (d[0]) begin m_go = 1; m_cnt = 2; end
         end
      end
   endtask

   initial model_reset();
   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
   end

   // stimulus helpers: compare at the falling edge, then drive
   task automatic tick(input bit wr, input bit rd, input int a, input logic [31:0] d);
      logic [31:0] exp;
      @(negedge clk);
      exp = model_rd(host_addr);
      n_tests++;
      if (host_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s reg %0d actual %h expected %h", cur_req, host_addr, host_rdata, exp);
      end
      host_wr = wr; host_rd = rd; host_addr = a[4:0]; host_wdata = d;
   endtask

   task automatic peek(input int a);
      tick(0, 0, a, 0);
   endtask
   task automatic wreg(input int a, input logic [31:0] d);
      tick(1, 0, a, d);
   endtask
   task automatic ctrl(input int op, input int sel, input int idx, input bit go);
      wreg(0, (idx << 8) | (sel << 3) | (op << 1) | go);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) peek(0);
   endtask
   task automatic dump_all();
      for (int a = 0; a <= 19; a++) peek(a);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired during %s", cur_req);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      dump_all();

      cur_req = "R3";
      wreg(1, 32'h0000_0005); wreg(4, 32'hAABB_CCDD); wreg(8, 32'h0000_0003);
      wreg(9, 32'hFFFF_FF0F); wreg(16, 32'h0000_00FF);
      ctrl(2, 0, 3, 1); idle(3);
      wreg(1, 32'h0000_0002); wreg(6, 32'h0000_1234);
      ctrl(2, 0, 5, 1); idle(3);
      wreg(1, 32'h0000_0000); wreg(2, 32'hDEAD_0000);
      ctrl(2, 0, 9, 1); idle(3);
      wreg(17, 32'h8000_0011); ctrl(2, 1, 3, 1); idle(3);
      wreg(18, 32'h0000_0007); ctrl(2, 2, 3, 1); idle(3);
      wreg(1, 32'h0000_0003); ctrl(2, 0, 0, 1); idle(3);

      cur_req = "R2";
      for (int a = 1; a <= 18; a++) wreg(a, 32'h0);
      ctrl(1, 0, 0, 1); idle(3); dump_all();   // R3: entry 0 still zero
      ctrl(1, 0, 3, 1); idle(3); dump_all();
      ctrl(1, 1, 3, 1); idle(3); peek(17);
      ctrl(1, 2, 3, 1); idle(3); peek(18);

      cur_req = "R9";
      ctrl(1, 0, 5, 1); peek(0); wreg(2, 32'hFFFF_FFFF); peek(2); peek(1); peek(6);

      cur_req = "R4";
      ctrl(1, 0, 3, 1); ctrl(2, 1, 7, 1); idle(3); peek(0);

      cur_req = "R6";
      tick(0, 1, 8, 0); idle(2);

      cur_req = "R5";
      ctrl(3, 0, 1, 1); idle(12);
      cur_req = "R6";
      dump_all(); tick(0, 1, 2, 0); idle(3);
      tick(0, 1, 8, 0); idle(10);
      dump_all(); tick(0, 1, 8, 0);
      cur_req = "R7";
      idle(30); peek(0);

      cur_req = "R10";
      ctrl(1, 0, 5, 1); idle(3);
      wreg(1, 32'h0000_0000); ctrl(2, 0, 5, 1); idle(3);
      ctrl(3, 0, 1, 1); idle(12); tick(0, 1, 8, 0); idle(30); dump_all();

      cur_req = "R7";
      ctrl(3, 0, 6, 1); idle(25);

      cur_req = "R8";
      wreg(0, 32'h0000_0020); ctrl(1, 0, 3, 1); idle(20);
      ctrl(3, 0, 1, 1); idle(36);
      ctrl(1, 0, 3, 1); idle(3); dump_all();
      ctrl(1, 1, 3, 1); idle(3); peek(17);

      peek(0);
      summary();
      $finish;
   end
endmodule